// File: doc/BRIEF.md
# SMBus Write Command Decoder

This block sits behind an SMBus slave front-end that has already turned bus activity into start and stop events and whole bytes. It reads the write transactions that arrive this way. For each byte it decides whether to acknowledge, and it turns the transaction into one of four actions: load the RAM address pointer, write one byte into the register file, load the 16-bit EEPROM address pointer, or raise a page-erase request.

The command byte chooses what the transaction means. A low range of codes names a register-file location. A small block of codes near the top carries the high half of an EEPROM address, and the data byte that follows carries the low half. A single reserved code asks for a page erase of the page that the EEPROM pointer selects. All other codes are acknowledged and have no effect. While the external busy input is high, the block refuses the address byte, so a busy device ignores the whole transaction.

Every decision is taken on the clock edge where `byte_vld_i` is high. The resulting acknowledge and any action pulse show up together in the next cycle.

Top module: `smb_wr_decoder`

## Requirements
- R1: After reset, `ack_o`, `reg_we_o` and `erase_req_o` are low, and `ram_ptr_o` and `ee_addr_o` are zero.
- R2: The first byte after start is acknowledged (`ack_o` high for one cycle, the cycle after `byte_vld_i`) only when bits 7:1 equal `SLV_ADDR`, bit 0 (the read/write bit) is 0, and `busy_i` is low.
- R3: When the address byte is refused, every later byte up to the next start is not acknowledged and changes no output.
- R4: A command byte in 0x00..0xDF is acknowledged and loads `ram_ptr_o` with its value in the next cycle. This also happens when no data follows (send byte).
- R5: A command in 0x00..0xDF followed by a data byte gives a one-cycle `reg_we_o` pulse in the cycle after the data byte, with `reg_waddr_o` equal to the command and `reg_wdata_o` equal to the data.
- R6: A command in 0xF8..0xFB followed by a data byte sets `ee_addr_o` to {command, data} in the cycle after the data byte and gives no register write.
- R7: Command 0xFE gives a one-cycle `erase_req_o` pulse in the cycle after the command byte, whatever follows, and leaves `ram_ptr_o` unchanged.
- R8: Commands 0xE0..0xF7, 0xFC, 0xFD and 0xFF are acknowledged and change no output. A data byte after such a command, or after 0xFE, is not acknowledged.
- R9: A second data byte after a RAM or EEPROM command is acknowledged and has no effect. Any further byte is not acknowledged.
- R10: Stop ends the transaction. Bytes that arrive before the next start are not acknowledged. A repeated start without stop begins again at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte |
| busy_i | input | 1 | Device busy; the address byte is refused |
| ack_o | output | 1 | Acknowledge decision for the last byte, one cycle after the strobe |
| reg_we_o | output | 1 | Register-file write strobe |
| reg_waddr_o | output | 8 | Register-file write address |
| reg_wdata_o | output | 8 | Register-file write data |
| ram_ptr_o | output | 8 | RAM address pointer for later reads |
| ee_addr_o | output | 16 | EEPROM address pointer |
| erase_req_o | output | 1 | One-cycle page-erase request |

## Verification
Random transactions mix matching, mismatching and read-bit addresses, busy and idle device states, commands drawn from each code class, and zero to three data bytes. This separates the send-byte action from the write action and the erase code from undefined codes. Directed cases cover the range edges 0xDF/0xE0, 0xF7/0xF8 and 0xFB/0xFC. They also cover an erase followed by a stray data byte, bytes sent after stop, and a repeated start with no stop. Together these show that refusal lasts to the next start and that the pointers move only on their own events.

// File: rtl/smb_dec_pkg.sv
package smb_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int EE_AW  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_DAT1, ST_DAT2, ST_SKIP
  } txn_st_e;

  typedef enum logic [1:0] {
    CK_RAM, CK_EEHI, CK_ERASE, CK_NONE
  } cmd_kind_e;

  // Map a command code onto its meaning, given the code boundaries.
  function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] code,
                                         input logic [BYTE_W-1:0] ram_last,
                                         input logic [BYTE_W-1:0] ee_first,
                                         input logic [BYTE_W-1:0] ee_last,
                                         input logic [BYTE_W-1:0] erase_code);
    if (code <= ram_last)                         return CK_RAM;
    else if (code >= ee_first && code <= ee_last) return CK_EEHI;
    else if (code == erase_code)                  return CK_ERASE;
    else                                          return CK_NONE;
  endfunction

  // Address byte hits when the 7-bit address matches and the write bit is 0.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [BYTE_W-2:0] slave);
    return (b[BYTE_W-1:1] == slave) && !b[0];
  endfunction
endpackage

// File: rtl/smb_txn_fsm.sv
module smb_txn_fsm
  import smb_dec_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR   = 7'h34,
  parameter logic [7:0] RAM_LAST   = 8'hDF,
  parameter logic [7:0] EE_FIRST   = 8'hF8,
  parameter logic [7:0] EE_LAST    = 8'hFB,
  parameter logic [7:0] ERASE_CODE = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              busy_i,
  output logic              ack_o,
  output logic              cmd_evt_o,
  output logic              data_evt_o
);
  txn_st_e   st_q;
  cmd_kind_e kind_q;
  logic      framed;
  logic      kind_has_data;
  logic      addr_ok;

  assign framed        = byte_vld_i && !start_i && !stop_i;
  assign kind_has_data = (kind_q == CK_RAM) || (kind_q == CK_EEHI);
  assign addr_ok       = addr_hit(byte_i, SLV_ADDR) && !busy_i;
  assign cmd_evt_o     = framed && (st_q == ST_CMD);
  assign data_evt_o    = framed && (st_q == ST_DAT1) && kind_has_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= CK_NONE;
      ack_o  <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      if (start_i) begin
        st_q <= ST_ADDR;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
      end else if (byte_vld_i) begin
        unique case (st_q)
          ST_ADDR: begin
            ack_o <= addr_ok;
            st_q  <= addr_ok ? ST_CMD : ST_SKIP;
          end
          ST_CMD: begin
            ack_o  <= 1'b1;
            kind_q <= classify(byte_i, RAM_LAST, EE_FIRST, EE_LAST, ERASE_CODE);
            st_q   <= ST_DAT1;
          end
          ST_DAT1: begin
            ack_o <= kind_has_data;
            st_q  <= kind_has_data ? ST_DAT2 : ST_SKIP;
          end
          ST_DAT2: begin
            ack_o <= 1'b1;
            st_q  <= ST_SKIP;
          end
          default: ack_o <= 1'b0;
        endcase
      end
    end
  end

  // R2
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(byte_vld_i));

  // R3
  skip_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP && framed) |=> !ack_o);

  // R10
  idle_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && framed) |=> !ack_o);
endmodule

// File: rtl/smb_cmd_exec.sv
module smb_cmd_exec
  import smb_dec_pkg::*;
#(
  parameter logic [7:0] RAM_LAST   = 8'hDF,
  parameter logic [7:0] EE_FIRST   = 8'hF8,
  parameter logic [7:0] EE_LAST    = 8'hFB,
  parameter logic [7:0] ERASE_CODE = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_evt_i,
  input  logic              data_evt_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] ram_ptr_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              erase_req_o
);
  logic [BYTE_W-1:0] cmd_q;
  cmd_kind_e         new_kind;
  cmd_kind_e         held_kind;

  assign new_kind  = classify(byte_i, RAM_LAST, EE_FIRST, EE_LAST, ERASE_CODE);
  assign held_kind = classify(cmd_q, RAM_LAST, EE_FIRST, EE_LAST, ERASE_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      ram_ptr_o   <= '0;
      ee_addr_o   <= '0;
      reg_we_o    <= 1'b0;
      reg_waddr_o <= '0;
      reg_wdata_o <= '0;
      erase_req_o <= 1'b0;
    end else begin
      reg_we_o    <= 1'b0;
      erase_req_o <= 1'b0;
      if (cmd_evt_i) begin
        cmd_q <= byte_i;
        if (new_kind == CK_RAM)   ram_ptr_o   <= byte_i;
        if (new_kind == CK_ERASE) erase_req_o <= 1'b1;
      end
      if (data_evt_i) begin
        if (held_kind == CK_RAM) begin
          reg_we_o    <= 1'b1;
          reg_waddr_o <= cmd_q;
          reg_wdata_o <= byte_i;
        end
        if (held_kind == CK_EEHI) ee_addr_o <= {cmd_q, byte_i};
      end
    end
  end

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_evt_i) |-> $stable(ram_ptr_o));

  // R5
  we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> $past(data_evt_i));

  // R6
  ee_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_evt_i) |-> $stable(ee_addr_o));

  // R7
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |-> ($past(cmd_evt_i) && !reg_we_o));
endmodule

// File: rtl/smb_wr_decoder.sv
module smb_wr_decoder
  import smb_dec_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR   = 7'h34,
  parameter logic [7:0] RAM_LAST   = 8'hDF,
  parameter logic [7:0] EE_FIRST   = 8'hF8,
  parameter logic [7:0] EE_LAST    = 8'hFB,
  parameter logic [7:0] ERASE_CODE = 8'hFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        busy_i,
  output logic        ack_o,
  output logic        reg_we_o,
  output logic [7:0]  reg_waddr_o,
  output logic [7:0]  reg_wdata_o,
  output logic [7:0]  ram_ptr_o,
  output logic [15:0] ee_addr_o,
  output logic        erase_req_o
);
  logic cmd_evt;
  logic data_evt;

  smb_txn_fsm #(
    .SLV_ADDR(SLV_ADDR), .RAM_LAST(RAM_LAST), .EE_FIRST(EE_FIRST),
    .EE_LAST(EE_LAST), .ERASE_CODE(ERASE_CODE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .busy_i(busy_i),
    .ack_o(ack_o), .cmd_evt_o(cmd_evt), .data_evt_o(data_evt)
  );

  smb_cmd_exec #(
    .RAM_LAST(RAM_LAST), .EE_FIRST(EE_FIRST),
    .EE_LAST(EE_LAST), .ERASE_CODE(ERASE_CODE)
  ) u_exec (
    .clk(clk), .rst_n(rst_n), .cmd_evt_i(cmd_evt), .data_evt_i(data_evt),
    .byte_i(byte_i), .ram_ptr_o(ram_ptr_o), .ee_addr_o(ee_addr_o),
    .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o),
    .erase_req_o(erase_req_o)
  );

  // R8
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_we_o, erase_req_o}) <= 1);

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!ack_o && !reg_we_o && !erase_req_o);
    end
  end
endmodule

// File: tb/smb_wr_decoder_test.sv
`timescale 1ns/1ps
module smb_wr_decoder_test;
  localparam logic [6:0] SA = 7'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, busy_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        ack_o, reg_we_o, erase_req_o;
  logic [7:0]  reg_waddr_o, reg_wdata_o, ram_ptr_o;
  logic [15:0] ee_addr_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state: 0 idle, 1 addr, 2 cmd, 3 data1, 4 data2, 5 skip
  int         m_st = 0;
  logic [7:0] m_cmd = 8'h00;
  logic [7:0] e_ptr = 8'h00;
  logic [15:0] e_ee = 16'h0000;

  always #2.5 clk = ~clk;

  smb_wr_decoder #(.SLV_ADDR(SA)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .busy_i(busy_i),
    .ack_o(ack_o), .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o),
    .reg_wdata_o(reg_wdata_o), .ram_ptr_o(ram_ptr_o), .ee_addr_o(ee_addr_o),
    .erase_req_o(erase_req_o)
  );

  function automatic bit is_ram(input logic [7:0] c); return c < 8'hE0; endfunction
  function automatic bit is_ee(input logic [7:0] c);  return c[7:2] == 6'b111110; endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    m_st = 1;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    m_st = 0;
  endtask

  task automatic send(input logic [7:0] b);
    bit e_ack = 0, e_we = 0, e_er = 0;
    logic [7:0] e_wa = 8'h00;
    string req;
    case (m_st)
      1: begin
        e_ack = (b[7:1] == SA) && !b[0] && !busy_i;
        req = e_ack ? "R2" : "R3";
        m_st = e_ack ? 2 : 5;
      end
      2: begin
        e_ack = 1; m_cmd = b; m_st = 3;
        if (is_ram(b)) begin e_ptr = b; req = "R4"; end
        else if (b == 8'hFE) begin e_er = 1; req = "R7"; end
        else req = "R8";
      end
      3: begin
        if (is_ram(m_cmd)) begin e_ack = 1; e_we = 1; e_wa = m_cmd; req = "R5"; m_st = 4; end
        else if (is_ee(m_cmd)) begin e_ack = 1; e_ee = {m_cmd, b}; req = "R6"; m_st = 4; end
        else begin e_ack = 0; req = "R8"; m_st = 5; end
      end
      4: begin e_ack = 1; req = "R9"; m_st = 5; end
      5: req = "R3";
      default: req = "R10";
    endcase
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0;
    chk(req, "ack", ack_o, e_ack);
    chk(req, "reg_we", reg_we_o, e_we);
    if (e_we) begin
      chk(req, "waddr", reg_waddr_o, e_wa);
      chk(req, "wdata", reg_wdata_o, b);
    end
    chk(req, "erase", erase_req_o, e_er);
    chk(req, "ram_ptr", ram_ptr_o, e_ptr);
    chk(req, "ee_addr", ee_addr_o, e_ee);
    @(negedge clk);
    chk("R7", "erase one cycle", erase_req_o, 0);
    chk("R5", "we one cycle", reg_we_o, 0);
  endtask

  function automatic logic [7:0] rand_cmd();
    int r = $urandom % 8;
    if (r < 4) return 8'($urandom % 224);
    if (r < 6) return 8'hF8 + 8'($urandom % 4);
    if (r == 6) return 8'hFE;
    r = $urandom % 27;
    if (r < 24) return 8'hE0 + 8'(r);
    if (r == 24) return 8'hFC;
    if (r == 25) return 8'hFD;
    return 8'hFF;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ack", ack_o, 0);
    chk("R1", "we", reg_we_o, 0);
    chk("R1", "erase", erase_req_o, 0);
    chk("R1", "ram_ptr", ram_ptr_o, 0);
    chk("R1", "ee_addr", ee_addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: range edges and write of RAM
    do_start(); send({SA,1'b0}); send(8'hDF); send(8'h5A); do_stop();
    do_start(); send({SA,1'b0}); send(8'hE0); send(8'h11); do_stop();
    do_start(); send({SA,1'b0}); send(8'hF7); do_stop();
    do_start(); send({SA,1'b0}); send(8'hF8); send(8'hA0); send(8'h01); send(8'h02); do_stop();
    do_start(); send({SA,1'b0}); send(8'hFB); send(8'h3C); do_stop();
    do_start(); send({SA,1'b0}); send(8'hFC); send(8'h77); do_stop();
    // send byte: pointer only
    do_start(); send({SA,1'b0}); send(8'h00); do_stop();
    // erase, then a stray data byte, then stop
    do_start(); send({SA,1'b0}); send(8'hFE); send(8'h99); do_stop();
    // mismatch, read bit, busy
    do_start(); send({SA ^ 7'h01,1'b0}); send(8'h10); send(8'h20); do_stop();
    do_start(); send({SA,1'b1}); send(8'h10); do_stop();
    busy_i = 1'b1;
    do_start(); send({SA,1'b0}); send(8'hFE); send(8'h55); do_stop();
    busy_i = 1'b0;
    // bytes after stop, then repeated start
    send(8'h42); send({SA,1'b0});
    do_start(); send({SA,1'b0}); send(8'h21);
    do_start(); send({SA,1'b0}); send(8'h22); send(8'hC3); do_stop();

    // random transactions
    for (int t = 0; t < 300; t++) begin
      int nd = $urandom % 4;
      logic [6:0] a = ($urandom % 8 == 0) ? 7'($urandom) : SA;
      logic rw = ($urandom % 10 == 0);
      busy_i = ($urandom % 8 == 0);
      do_start();
      send({a, rw});
      send(rand_cmd());
      for (int d = 0; d < nd; d++) send(8'($urandom));
      if ($urandom % 10 != 0) do_stop();
    end
    busy_i = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule